// File: doc/BRIEF.md
# Shadowed Phase-Accumulator PWM Channel

This block produces one pulse-width-modulated output whose settings live in a single 32-bit control word. A phase accumulator of `BU_W` bits adds a programmable increment, the base unit, on every clock. Each wrap of the accumulator starts a new output cycle, so the output frequency is `base_unit * f_clk / 2^BU_W`. The top eight accumulator bits form the phase. The output is high while that phase exceeds an 8-bit threshold that is stored inverted: 255 gives a constantly low output and 0 gives an output that is high for all but the first phase step.

Software writes new settings into a staged copy of the word. Setting the update-request bit in a write arms a commit. The staged base unit and threshold are copied to the active set at the next accumulator wrap, or on the next clock if the channel is disabled, and the hardware then clears the request bit. A second write that arrives while a commit is still armed locks the channel. Later writes still land in the readable word but no longer reach the output, and only reset releases the lock. The enable bit acts at once and does not wait for a commit. `BU_W` must lie between 9 and 22.

Top module: `pwm_phase_channel`

## Requirements
- R1: After reset, `rd_data` reads 0 and `pwm_out` is low.
- R2: Control word layout: bit 31 is enable, bit 30 is update request/pending, bits `8+BU_W-1:8` are the base unit, and bits 7:0 are the inverted threshold. When no update is pending, a read returns every bit exactly as last written.
- R3: While enabled, the accumulator adds the active base unit on every clock. An output cycle lasts `2^BU_W / base_unit` clocks when the base unit divides `2^BU_W`, and it starts at the wrap.
- R4: `pwm_out` is high exactly when the top 8 accumulator bits are greater than the active threshold. A threshold of 0xFF gives no high cycles, and a threshold of 0x00 gives high on every phase except phase 0.
- R5: A write with bit 30 set makes bit 30 read 1. The staged base unit and threshold become active at the next wrap, and in that same cycle bit 30 reads 0 and the new cycle begins at phase 0.
- R6: While the channel is disabled, a pending update commits on the next clock.
- R7: A write accepted while bit 30 is pending, including one on the very clock of a wrap, locks the channel. Bit 30 then stays 1, the output keeps its previous settings and enable, and later writes change only the read-back value.
- R8: A write that clears enable drives `pwm_out` low from the next cycle and holds the accumulator at zero. A write that sets enable starts a cycle at phase 0.
- R9: An active base unit of 0 never advances the accumulator, so the output stays low.
- R10: Reset releases a lock: after reset, updates commit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back, bit 30 shows a pending update |
| pwm_out | output | 1 | PWM output |

## Verification
Two functions can meet on one clock edge: a write to the control word and the accumulator wrap that would commit an armed update. The bench enables the channel at a known edge, arms an update one clock later, and counts clocks so that a second write lands exactly on the eighth edge, where the wrap occurs. The result is judged at the ports. Bit 30 must still read 1 long afterwards, and the duty must stay at the pre-update value. A design that lets the commit win would clear bit 30 and switch to the new threshold.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

    localparam int WORD_W  = 32;
    localparam int EN_POS  = 31;
    localparam int UPD_POS = 30;
    localparam int THR_W   = 8;
    localparam int BU_LSB  = 8;

    typedef enum logic [1:0] {
        ST_SETTLED = 2'd0,
        ST_ARMED   = 2'd1,
        ST_LOCKED  = 2'd2
    } upd_state_e;

    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] thr;
    } chan_view_t;

    function automatic logic word_enable(input logic [WORD_W-1:0] w);
        return w[EN_POS];
    endfunction

    function automatic logic word_update(input logic [WORD_W-1:0] w);
        return w[UPD_POS];
    endfunction

    function automatic logic [THR_W-1:0] word_thr(input logic [WORD_W-1:0] w);
        return w[THR_W-1:0];
    endfunction

endpackage

// File: rtl/pwmch_ctrl.sv
module pwmch_ctrl
    import pwmch_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              boundary,
    output logic [WORD_W-1:0] rd_data,
    output logic              en_act,
    output logic [BU_W-1:0]   bu_act,
    output logic [THR_W-1:0]  thr_act,
    output upd_state_e        state
);
    logic [WORD_W-1:0] staged;
    chan_view_t        view;
    logic              commit_ok;

    assign view.en    = en_act;
    assign view.thr   = thr_act;
    assign commit_ok  = boundary || !view.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged  <= '0;
            state   <= ST_SETTLED;
            en_act  <= 1'b0;
            bu_act  <= '0;
            thr_act <= '0;
        end else begin
            case (state)
                ST_SETTLED: begin
                    if (wr_en) begin
                        staged <= wr_data;
                        en_act <= word_enable(wr_data);
                        if (word_update(wr_data)) state <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (wr_en) begin
                        staged <= wr_data;
                        state  <= ST_LOCKED;
                    end else if (commit_ok) begin
                        bu_act  <= staged[BU_LSB +: BU_W];
                        thr_act <= word_thr(staged);
                        state   <= ST_SETTLED;
                    end
                end
                ST_LOCKED: begin
                    if (wr_en) staged <= wr_data;
                end
                default: state <= ST_SETTLED;
            endcase
        end
    end

    always_comb begin
        rd_data          = staged;
        rd_data[UPD_POS] = (state != ST_SETTLED);
    end
endmodule

// File: rtl/pwmch_accum.sv
module pwmch_accum #(
    parameter int BU_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [BU_W-1:0] step,
    output logic [BU_W-1:0] acc,
    output logic            boundary
);
    logic [BU_W:0] sum;

    assign sum      = {1'b0, acc} + {1'b0, step};
    assign boundary = en && sum[BU_W];

    always_ff @(posedge clk) begin
        if (rst || !en) acc <= '0;
        else            acc <= sum[BU_W-1:0];
    end
endmodule

// File: rtl/pwmch_duty.sv
module pwmch_duty
    import pwmch_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             en,
    input  logic [BU_W-1:0]  acc,
    input  logic [THR_W-1:0] thr,
    output logic             pwm
);
    localparam int FRAC_W = BU_W - THR_W;

    logic [BU_W-1:0] limit;

    // phase > thr  <=>  acc > {thr, all ones below the phase}
    assign limit = {thr, {FRAC_W{1'b1}}};
    assign pwm   = en && (acc > limit);
endmodule

// File: rtl/pwm_phase_channel.sv
module pwm_phase_channel
    import pwmch_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    logic             en_act;
    logic [BU_W-1:0]  bu_act;
    logic [BU_W-1:0]  acc;
    logic [THR_W-1:0] thr_act;
    logic             boundary;
    logic             pending;
    logic             frozen;
    upd_state_e       state;

    pwmch_ctrl #(.BU_W(BU_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .boundary (boundary),
        .rd_data  (rd_data),
        .en_act   (en_act),
        .bu_act   (bu_act),
        .thr_act  (thr_act),
        .state    (state)
    );

    pwmch_accum #(.BU_W(BU_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .en       (en_act),
        .step     (bu_act),
        .acc      (acc),
        .boundary (boundary)
    );

    pwmch_duty #(.BU_W(BU_W)) u_duty (
        .en  (en_act),
        .acc (acc),
        .thr (thr_act),
        .pwm (pwm_out)
    );

    assign pending = (state != ST_SETTLED);
    assign frozen  = (state == ST_LOCKED);
endmodule

// File: rtl/pwmch_checker.sv
module pwmch_checker #(
    parameter int BU_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            pwm_out,
    input logic            pending,
    input logic            frozen,
    input logic            boundary,
    input logic            en_act,
    input logic [BU_W-1:0] acc,
    input logic [BU_W-1:0] bu_act
);
    AST_LOCK_ON_REWRITE: assert property (@(posedge clk) disable iff (rst)
        (pending && wr_en) |=> frozen); // R7

    AST_LOCK_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
        frozen |=> (frozen && pending)); // R7

    AST_CLEAR_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> ($past(boundary) || !$past(en_act))); // R5 R6

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_act |-> !pwm_out); // R8

    AST_IDLE_ACC_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en_act |=> (acc == '0)); // R8

    AST_ZERO_STEP_LOW: assert property (@(posedge clk) disable iff (rst)
        (en_act && bu_act == '0 && acc == '0) |=> !pwm_out); // R9
endmodule

bind pwm_phase_channel pwmch_checker #(.BU_W(BU_W)) u_pwmch_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .pwm_out  (pwm_out),
    .pending  (pending),
    .frozen   (frozen),
    .boundary (boundary),
    .en_act   (en_act),
    .acc      (acc),
    .bu_act   (bu_act)
);

// File: tb/pwm_phase_channel_bench.sv
module pwm_phase_channel_bench;
    localparam int BU_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];

    pwm_phase_channel #(.BU_W(BU_W)) u_pwm_phase_channel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #10 clk = ~clk;

    // monitor: compares produced results against queued expectations
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                item_t e;
                item_t a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                total++;
                if (e.val != a.val) begin
                    bad++;
                    $display("FAIL %s actual=%0d expected=%0d", e.tag, a.val, e.val);
                end
            end
        end
    end

    task automatic check(input string tag, input int expv, input int actv);
        item_t e;
        item_t a;
        e.tag = tag; e.val = expv;
        a.tag = tag; a.val = actv;
        exp_q.push_back(e);
        act_q.push_back(a);
        #0;
    endtask

    function automatic logic [31:0] cw(input bit en, input bit upd,
                                       input int bu, input int thr);
        return (32'(en) << 31) | (32'(upd) << 30) |
               ((32'(bu) & ((32'd1 << BU_W) - 1)) << 8) | (32'(thr) & 32'hFF);
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic period(output int p);
        logic prev;
        int   k;
        @(negedge clk);
        prev = pwm_out;
        k = 0;
        while (!(pwm_out && !prev) && k < 200) begin
            prev = pwm_out; @(negedge clk); k++;
        end
        p = 0;
        prev = pwm_out;
        @(negedge clk); p++; 
        while (!(pwm_out && !prev) && p < 200) begin
            prev = pwm_out; @(negedge clk); p++;
        end
    endtask

    // apply an update on a running channel and wait for the commit
    task automatic update_running(input string tag, input logic [31:0] d);
        int n;
        wr(d & ~32'h4000_0000);
        wr(d | 32'h4000_0000);
        @(negedge clk);
        check({tag, " R5 pending set"}, 1, int'(rd_data[30]));
        n = 0;
        while (rd_data[30] && n < 100) begin
            @(negedge clk); n++;
        end
        check({tag, " R5 committed within one cycle"}, 1, int'(n <= 17));
        check({tag, " R5 new cycle at phase 0"}, 0, int'(pwm_out));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi;
        int p;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset read", 0, int'(rd_data));
        check("R1 reset out", 0, int'(pwm_out));

        // R2: read-back of every field
        wr(32'h2A00_1234);
        @(negedge clk);
        check("R2 readback", 32'h2A00_1234, int'(rd_data));

        // R6: idle commit, then R8 phase-zero start and R3/R4 duty
        wr(cw(0, 1, 16'h1000, 8'h7F));
        @(negedge clk);
        check("R6 idle pending visible", 1, int'(rd_data[30]));
        @(negedge clk);
        check("R6 idle commit next clock", 0, int'(rd_data[30]));
        wr(cw(1, 0, 16'h1000, 8'h7F));
        count_high(8, hi);
        check("R8 starts at phase 0 (low half)", 0, hi);
        count_high(8, hi);
        check("R8 R4 second half high", 8, hi);
        period(p);
        check("R3 period 16", 16, p);
        check("R2 enable reads back", 1, int'(rd_data[31]));

        update_running("bu2000", cw(1, 0, 16'h2000, 8'h7F));
        count_high(8, hi);
        check("R4 half duty at period 8", 4, hi);
        period(p);
        check("R3 period 8", 8, p);

        update_running("thrFF", cw(1, 0, 16'h2000, 8'hFF));
        count_high(16, hi);
        check("R4 threshold FF never high", 0, hi);

        update_running("thr00", cw(1, 0, 16'h2000, 8'h00));
        count_high(8, hi);
        check("R4 threshold 00 high 7 of 8", 7, hi);

        // R8: disable
        wr(cw(0, 0, 16'h2000, 8'h00));
        count_high(20, hi);
        check("R8 disabled low", 0, hi);

        // R7: second write on the wrap edge while armed
        wr(cw(1, 0, 16'h2000, 8'h00));          // edge E
        wr(cw(1, 1, 16'h2000, 8'hFF));          // edge E+1
        repeat (6) @(posedge clk);              // up to E+7
        wr(cw(0, 1, 16'h4000, 8'h80));          // edge E+8, the wrap
        repeat (50) @(negedge clk);
        check("R7 locked pending stays", 1, int'(rd_data[30]));
        count_high(8, hi);
        check("R7 output keeps old threshold and enable", 7, hi);
        check("R7 readback shows latest write", int'(cw(0, 1, 16'h4000, 8'h80)), int'(rd_data));
        wr(cw(0, 0, 16'h1000, 8'hFF));
        count_high(8, hi);
        check("R7 later write no effect", 7, hi);
        check("R7 pending still set", 1, int'(rd_data[30]));

        // R10: reset releases the lock
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10 R1 reset read after lock", 0, int'(rd_data));
        check("R10 R1 reset out after lock", 0, int'(pwm_out));
        wr(cw(0, 1, 16'h2000, 8'h7F));
        repeat (2) @(negedge clk);
        check("R10 commit works again", 0, int'(rd_data[30]));
        wr(cw(1, 0, 16'h2000, 8'h7F));
        count_high(8, hi);
        check("R10 output after unlock", 4, hi);

        // R9: base unit zero
        wr(cw(0, 1, 0, 8'h00));
        repeat (2) @(negedge clk);
        wr(cw(1, 0, 0, 8'h00));
        count_high(40, hi);
        check("R9 zero base unit stays low", 0, hi);

        wait (act_q.size() == 0);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule